// File: doc/BRIEF.md
# Sentry-Bit Way Enable Filter

This block sits beside a set-associative cache and decides which ways are worth powering on a lookup. For every way of every set it keeps a short sentry entry: a valid flag and the lowest few bits of the tag held in that way. Those bits live only here and are no longer stored in the main tag array. On each request the entries of the addressed set are compared with the request's own sentry bits. The result is a per-way enable vector that gates the word lines of the tag and data arrays. Only ways whose sentry agrees can hold the line, so all other ways stay idle.

When no way agrees, the request cannot hit. The block then raises a sure-miss flag, so that the refill can start without any array access. The filter runs only when the single-line buffer in front of the cache has missed. On a buffer hit, every enable stays low. When a line is refilled after a miss, the caller names the victim way, and the entry of that way is rewritten with the new tag's sentry bits.

The caller passes the address from the first bit above the line offset upward. That slice holds the set index followed by the sentry bits. A response appears one clock after its request.

Top module: `sentry_way_filter`

## Requirements
- R1: After reset every sentry entry is invalid and all outputs are low. A lookup after reset gives no enables and raises the sure-miss flag.
- R2: The address slice `req_addr`/`fill_addr` carries the set index in bits [INDEX_W-1:0] and the sentry in bits [INDEX_W+SENTRY_W-1:INDEX_W]. INDEX_W is clog2(NUM_SETS). The sentry is the lowest SENTRY_W bits of the tag.
- R3: For a request with `req_valid`=1 and `req_bb_hit`=0, the response in the next cycle has `rsp_way_en[w]`=1 exactly when entry w of the indexed set is valid and its sentry equals the request's sentry. Entries of other sets have no effect.
- R4: When several ways of the set hold the requested sentry, every one of them is enabled in the same response.
- R5: A filtered request with no agreeing way gives `rsp_sure_miss`=1 and `rsp_way_en`=0. Whenever `rsp_sure_miss` is 1, `rsp_way_en` is 0.
- R6: A refill (`fill_valid`=1) writes the sentry from `fill_addr` into way `fill_way` of the set in `fill_addr` and marks that entry valid. It replaces the entry's old sentry and leaves all other entries unchanged.
- R7: A way whose entry is invalid is never enabled, even when the stored bits equal the request's sentry.
- R8: A request with `req_bb_hit`=1 gives `rsp_valid`=1 with `rsp_way_en`=0 and `rsp_sure_miss`=0.
- R9: A lookup and a refill of the same set in the same cycle: the lookup sees the entries as they were before the refill, and a lookup in a later cycle sees the refilled entry.
- R10: `rsp_valid` is `req_valid` delayed by one cycle. A cycle with no request gives `rsp_valid`=0, `rsp_way_en`=0 and `rsp_sure_miss`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_bb_hit | input | 1 | Upstream line buffer already hit; filter is bypassed |
| req_addr | input | INDEX_W+SENTRY_W | Lookup address slice: set index, then sentry bits |
| fill_valid | input | 1 | Refill of one entry |
| fill_addr | input | INDEX_W+SENTRY_W | Refill address slice: set index, then new sentry bits |
| fill_way | input | WAY_W | Way being refilled |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_way_en | output | NUM_WAYS | Per-way word-line enable |
| rsp_sure_miss | output | 1 | No way can hit; miss known early |

## Verification
A lookup and a refill can fall in the same cycle on the same set. That is the normal case when a miss is serviced while the next access arrives. The bench drives both in one cycle, with the refilled sentry equal to the lookup's sentry on a way that was invalid. It expects a sure miss in that response, because the lookup must see the old entries. A second lookup one cycle later must then enable exactly the refilled way. Each response is judged against a sentry table that the bench keeps in its own terms.

// File: rtl/sentry_filt_pkg.sv
package sentry_filt_pkg;

  // Address width needed to index n items, at least one bit.
  function automatic int unsigned idx_bits(input int unsigned n);
    int unsigned b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction

  // Sentry field taken from the lookup slice {sentry, index}.
  function automatic logic [7:0] slice_sentry(input logic [31:0] slice,
                                              input int unsigned index_w,
                                              input int unsigned sentry_w);
    logic [31:0] sh;
    sh = slice >> index_w;
    return sh[7:0] & 8'((1 << sentry_w) - 1);
  endfunction

endpackage

// File: rtl/sentry_set_decoder.sv
module sentry_set_decoder #(
  parameter int NUM_SETS = 128,
  parameter int INDEX_W  = 7
) (
  input  logic [INDEX_W-1:0]  set_idx,
  output logic [NUM_SETS-1:0] set_line
);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_line
    assign set_line[s] = (set_idx == INDEX_W'(s));
  end

endmodule

// File: rtl/sentry_store.sv
module sentry_store #(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 4,
  parameter int SENTRY_W = 3,
  parameter int INDEX_W  = 7,
  parameter int WAY_W    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [INDEX_W-1:0]                 wr_set,
  input  logic [WAY_W-1:0]                   wr_way,
  input  logic [SENTRY_W-1:0]                wr_sentry,
  input  logic [NUM_SETS-1:0]                rd_line,
  output logic [NUM_WAYS-1:0][SENTRY_W-1:0]  rd_sentry,
  output logic [NUM_WAYS-1:0]                rd_valid
);

  logic [NUM_WAYS-1:0][SENTRY_W-1:0] ent_sentry [NUM_SETS];
  logic [NUM_WAYS-1:0]               ent_valid  [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic hit_wr;
      assign hit_wr = wr_en && (wr_set == INDEX_W'(s)) && (wr_way == WAY_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_valid[s][w]  <= 1'b0;
          ent_sentry[s][w] <= '0;
        end else if (hit_wr) begin
          ent_valid[s][w]  <= 1'b1;
          ent_sentry[s][w] <= wr_sentry;
        end
      end
    end
  end

  // Word-line style read: AND each set's row with its line, OR the rows.
  always_comb begin
    rd_sentry = '0;
    rd_valid  = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        rd_sentry[w] = rd_sentry[w] | (ent_sentry[s][w] & {SENTRY_W{rd_line[s]}});
        rd_valid[w]  = rd_valid[w]  | (ent_valid[s][w] & rd_line[s]);
      end
    end
  end

endmodule

// File: rtl/sentry_compare.sv
module sentry_compare #(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 4,
  parameter int SENTRY_W = 3
) (
  input  logic [NUM_SETS-1:0]               set_line,
  input  logic [NUM_WAYS-1:0][SENTRY_W-1:0] rd_sentry,
  input  logic [NUM_WAYS-1:0]               rd_valid,
  input  logic [SENTRY_W-1:0]               req_sentry,
  output logic [NUM_WAYS-1:0]               cand_vec
);

  logic set_active;
  assign set_active = |set_line;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign cand_vec[w] = set_active && rd_valid[w] && (rd_sentry[w] == req_sentry);
  end

endmodule

// File: rtl/sentry_way_filter.sv
module sentry_way_filter #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 128,
  parameter int SENTRY_W = 3,
  localparam int INDEX_W = sentry_filt_pkg::idx_bits(NUM_SETS),
  localparam int WAY_W   = sentry_filt_pkg::idx_bits(NUM_WAYS),
  localparam int SEL_W   = INDEX_W + SENTRY_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_bb_hit,
  input  logic [SEL_W-1:0]    req_addr,
  input  logic                fill_valid,
  input  logic [SEL_W-1:0]    fill_addr,
  input  logic [WAY_W-1:0]    fill_way,
  output logic                rsp_valid,
  output logic [NUM_WAYS-1:0] rsp_way_en,
  output logic                rsp_sure_miss
);

  logic [INDEX_W-1:0]                req_set;
  logic [SENTRY_W-1:0]               req_sentry;
  logic [INDEX_W-1:0]                fill_set;
  logic [SENTRY_W-1:0]               fill_sentry;
  logic                              fill_in_range;
  logic [NUM_SETS-1:0]               set_line;
  logic [NUM_WAYS-1:0][SENTRY_W-1:0] rd_sentry;
  logic [NUM_WAYS-1:0]               rd_valid;
  logic [NUM_WAYS-1:0]               cand_vec;
  logic                              filter_on;

  assign req_set     = req_addr[INDEX_W-1:0];
  assign req_sentry  = req_addr[SEL_W-1:INDEX_W];
  assign fill_set    = fill_addr[INDEX_W-1:0];
  assign fill_sentry = fill_addr[SEL_W-1:INDEX_W];
  assign fill_in_range = (32'(fill_way) < NUM_WAYS);
  assign filter_on   = req_valid && !req_bb_hit;

  sentry_set_decoder #(.NUM_SETS(NUM_SETS), .INDEX_W(INDEX_W)) u_dec (
    .set_idx  (req_set),
    .set_line (set_line)
  );

  sentry_store #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .SENTRY_W(SENTRY_W),
    .INDEX_W(INDEX_W), .WAY_W(WAY_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (fill_valid && fill_in_range),
    .wr_set    (fill_set),
    .wr_way    (fill_way),
    .wr_sentry (fill_sentry),
    .rd_line   (set_line),
    .rd_sentry (rd_sentry),
    .rd_valid  (rd_valid)
  );

  sentry_compare #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .SENTRY_W(SENTRY_W)
  ) u_cmp (
    .set_line   (set_line),
    .rd_sentry  (rd_sentry),
    .rd_valid   (rd_valid),
    .req_sentry (req_sentry),
    .cand_vec   (cand_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_way_en    <= '0;
      rsp_sure_miss <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_way_en    <= filter_on ? cand_vec : '0;
      rsp_sure_miss <= filter_on && (cand_vec == '0);
    end
  end

endmodule

// File: rtl/sentry_way_filter_chk.sv
module sentry_way_filter_chk #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_bb_hit,
  input logic                rsp_valid,
  input logic [NUM_WAYS-1:0] rsp_way_en,
  input logic                rsp_sure_miss,
  input logic [NUM_WAYS-1:0] cand_vec,
  input logic [NUM_WAYS-1:0] rd_valid,
  input logic [NUM_SETS-1:0] set_line
);

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_way_en == '0 && !rsp_sure_miss));

  // R8
  bb_hit_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bb_hit) |=> (rsp_way_en == '0 && !rsp_sure_miss));

  // R5
  miss_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_sure_miss |-> (rsp_way_en == '0));

  // R7
  invalid_never_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vec & ~rd_valid) == '0);

  // R3
  one_set_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(set_line) == 1);

  // R3
  rsp_from_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_bb_hit) |=> (rsp_way_en == $past(cand_vec)));

endmodule

bind sentry_way_filter sentry_way_filter_chk #(
  .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_bb_hit    (req_bb_hit),
  .rsp_valid     (rsp_valid),
  .rsp_way_en    (rsp_way_en),
  .rsp_sure_miss (rsp_sure_miss),
  .cand_vec      (cand_vec),
  .rd_valid      (rd_valid),
  .set_line      (set_line)
);

// File: tb/tb_sentry_way_filter.sv
module tb_sentry_way_filter;

  localparam int WAYS = 4;
  localparam int SETS = 128;
  localparam int SW   = 3;
  localparam int IW   = 7;
  localparam int WW   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_bb_hit = 1'b0;
  logic [IW+SW-1:0] req_addr = '0;
  logic            fill_valid = 1'b0;
  logic [IW+SW-1:0] fill_addr = '0;
  logic [WW-1:0]   fill_way = '0;
  logic            rsp_valid;
  logic [WAYS-1:0] rsp_way_en;
  logic            rsp_sure_miss;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // Bench's own table of entries (R6)
  logic [SW-1:0] m_sent [SETS][WAYS];
  logic          m_val  [SETS][WAYS];

  always #4 clk = ~clk;

  sentry_way_filter #(.NUM_WAYS(WAYS), .NUM_SETS(SETS), .SENTRY_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bb_hit(req_bb_hit),
    .req_addr(req_addr), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_way(fill_way), .rsp_valid(rsp_valid), .rsp_way_en(rsp_way_en),
    .rsp_sure_miss(rsp_sure_miss)
  );

  // R2: slice is {sentry, index}
  function automatic logic [IW+SW-1:0] mk(input int set, input int sent);
    return {SW'(sent), IW'(set)};
  endfunction

  function automatic logic [WAYS-1:0] expect_en(input int set, input int sent);
    logic [WAYS-1:0] v;
    v = '0;
    for (int w = 0; w < WAYS; w++)
      if (m_val[set][w] && m_sent[set][w] == SW'(sent)) v[w] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [WAYS+1:0] act, input logic [WAYS+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,en,miss} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic refill(input int set, input int way, input int sent);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = mk(set, sent); fill_way = WW'(way);
    @(negedge clk);
    fill_valid = 1'b0;
    m_val[set][way] = 1'b1; m_sent[set][way] = SW'(sent);
  endtask

  task automatic lookup(input string req, input int set, input int sent, input logic bb);
    logic [WAYS-1:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_bb_hit = bb; req_addr = mk(set, sent);
    e = bb ? '0 : expect_en(set, sent);
    @(negedge clk);
    req_valid = 1'b0; req_bb_hit = 1'b0;
    check(req, {rsp_valid, rsp_way_en, rsp_sure_miss}, {1'b1, e, (!bb && e == '0)});
  endtask

  task automatic t_reset;
    check("R1 reset outputs", {rsp_valid, rsp_way_en, rsp_sure_miss}, '0);
    lookup("R1 lookup after reset", 0, 0, 1'b0);
  endtask

  task automatic t_basic;
    refill(5, 0, 1);
    refill(5, 1, 2);
    refill(5, 2, 1);
    lookup("R4 two ways agree", 5, 1, 1'b0);
    check("R4 exact vector", {1'b0, rsp_way_en, 1'b0}, {1'b0, 4'b0101, 1'b0});
    lookup("R3 single way", 5, 2, 1'b0);
    lookup("R5 no agreeing way", 5, 3, 1'b0);
    lookup("R3 other set untouched", 6, 1, 1'b0);
    lookup("R7 invalid way with zero bits", 5, 0, 1'b0);
  endtask

  task automatic t_overwrite;
    refill(5, 0, 3);
    lookup("R6 old sentry gone", 5, 1, 1'b0);
    lookup("R6 new sentry present", 5, 3, 1'b0);
  endtask

  task automatic t_bypass;
    lookup("R8 buffer hit bypass", 5, 1, 1'b1);
    lookup("R8 buffer hit on empty set", 40, 0, 1'b1);
  endtask

  task automatic t_collide;
    @(negedge clk);
    req_valid = 1'b1; req_bb_hit = 1'b0; req_addr = mk(5, 6);
    fill_valid = 1'b1; fill_addr = mk(5, 6); fill_way = 2'd3;
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    check("R9 lookup sees old entry", {rsp_valid, rsp_way_en, rsp_sure_miss},
          {1'b1, 4'b0000, 1'b1});
    m_val[5][3] = 1'b1; m_sent[5][3] = 3'd6;
    lookup("R9 later lookup sees refill", 5, 6, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    check("R10 idle response", {rsp_valid, rsp_way_en, rsp_sure_miss}, '0);
  endtask

  task automatic t_sweep;
    // R2: top set index and all sentry values
    for (int w = 0; w < WAYS; w++) refill(SETS - 1, w, (w * 5 + 2) % 8);
    refill(SETS - 1, 3, 2);
    for (int s = 0; s < 8; s++) lookup("R2 sweep on last set", SETS - 1, s, 1'b0);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_val[s][w] = 1'b0; m_sent[s][w] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_overwrite();
    t_bypass();
    t_collide();
    t_idle();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule